// File: doc/BRIEF.md
# Bus-Mapped Wavetable Tone Generator

This block is a small audio tone source that sits on an 8-bit CPU I/O bus. Software picks a pitch by writing an 8-bit frequency code. The block turns that code into a 16-bit divisor of a fixed sample tick, which a prescaler derives from the system clock. On each divisor interval a 4-bit phase index steps once through a 16-sample period. The current sample is presented as an 8-bit unsigned code for an external DAC. A one-cycle load strobe marks each new sample.

There are two ways to map the code to a divisor. The first places the code in the upper byte of the divisor. The second looks the code up in a 256-entry computed note table, which gives finer pitch steps in the short-divisor range. A control bit picks sine or triangle output. The waveform can change, and a new pitch can be loaded, while the tone is running; neither action resets the phase.

Top module: `tone_gen_top`

## Requirements
- R1: After reset the phase index is 0, the DAC code is 0x80, the load strobe is low, the stored code is 0, sine output and shift mapping are selected, and both registers read as 0.
- R2: A write to the control port (address 98) sets the waveform from data bit 0 (0 = sine, 1 = triangle) and the mapping from data bit 1 (1 = note table). A read of port 98 returns {6'b0, mapping bit, waveform bit}.
- R3: A write to the data port (address 99) stores the frequency code, and a read of port 99 returns it. Writes to any other address change nothing. io_rdata is 0 when io_rd is low or the address matches neither port.
- R4: In shift mapping the divisor is {code, 8'h00}, and code 0 gives a divisor of 1. The load strobe then repeats every divisor × PRESCALE_DIV clock cycles.
- R5: In note-table mapping, let s = code[7:5] and f = code[4:0]. The divisor is (0xFFFE >> s) − f × (0xFFFE >> (s+5)). Every divisor lies between 1 and 0xFFFE.
- R6: A 24-bit prescaler issues one sample tick every PRESCALE_DIV clock cycles, and the phase advances only on a tick.
- R7: After every divisor ticks, the phase index advances by one and wraps from 15 to 0. dac_load is high for exactly the one cycle in which the new sample first appears.
- R8: In sine mode the codes for phases 0 to 15 are round(128 + 127·sin(2πk/16)).
- R9: In triangle mode the code is min(32k, 255) for k ≤ 8 and 32·(16−k) for k > 8.
- R10: A new divisor takes effect only when the interval already running ends. That interval keeps its old length, and the phase continues without reset.
- R11: A change of waveform selection changes dac_code in the cycle after the write. The phase is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read enable |
| io_rdata | output | 8 | Read data, combinational |
| dac_code | output | 8 | Current unsigned sample code |
| dac_load | output | 1 | One-cycle pulse when a new sample appears |

## Verification
The assertions take three things for granted about the inputs. Each write is a single-cycle io_wr pulse. io_rd and io_wr are never high together. The prescaler period is greater than one, which is what lets ticks be checked as isolated pulses. The stimulus drives every bus access for exactly one cycle on the falling edge, keeps reads and writes apart, and uses a prescaler of three so that every tick stands alone. The assertions check the phase-step and hold behaviour and the divisor bounds for any code the bus writes, so the table sweep also exercises the divisor range check.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int PHASE_W = 4;
    localparam int DIV_W   = 16;
    localparam int CODE_W  = 8;

    // Quarter-wave symmetric sine, 8-bit unsigned centred on 0x80
    function automatic logic [7:0] sine_code(input logic [PHASE_W-1:0] ph);
        logic [7:0] v;
        case (ph)
            4'd0:  v = 8'd128;
            4'd1:  v = 8'd177;
            4'd2:  v = 8'd218;
            4'd3:  v = 8'd245;
            4'd4:  v = 8'd255;
            4'd5:  v = 8'd245;
            4'd6:  v = 8'd218;
            4'd7:  v = 8'd177;
            4'd8:  v = 8'd128;
            4'd9:  v = 8'd79;
            4'd10: v = 8'd38;
            4'd11: v = 8'd11;
            4'd12: v = 8'd1;
            4'd13: v = 8'd11;
            4'd14: v = 8'd38;
            default: v = 8'd79;
        endcase
        return v;
    endfunction

    // Eight rising steps, eight falling steps, peak clipped to 255
    function automatic logic [7:0] tri_code(input logic [PHASE_W-1:0] ph);
        logic [8:0] v;
        if (ph <= 4'd8) v = {ph, 5'b0};
        else            v = {5'd16 - {1'b0, ph}, 5'b0};
        return (v > 9'd255) ? 8'd255 : v[7:0];
    endfunction

    // Code in the upper byte, with zero clamped to the shortest interval
    function automatic logic [DIV_W-1:0] shift_div(input logic [CODE_W-1:0] c);
        return (c == '0) ? DIV_W'(1) : {c, 8'h00};
    endfunction

    // Octave from the top three bits, linear fine step from the low five
    function automatic logic [DIV_W-1:0] note_div(input logic [CODE_W-1:0] c);
        int base;
        int step;
        base = 32'hFFFE >> c[7:5];
        step = 32'hFFFE >> (int'(c[7:5]) + 5);
        return DIV_W'(base - int'(c[4:0]) * step);
    endfunction

endpackage

// File: rtl/tone_bus_regs.sv
module tone_bus_regs
    import tone_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'd98,
    parameter logic [7:0] DATA_ADDR = 8'd99,
    parameter bit         TABLE_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       io_addr,
    input  logic [7:0]       io_wdata,
    input  logic             io_wr,
    input  logic             io_rd,
    output logic [7:0]       io_rdata,
    output logic             wave_sel,
    output logic [DIV_W-1:0] div_val
);

    typedef struct packed {
        logic              wave;
        logic              tbl;
        logic [CODE_W-1:0] code;
        logic [DIV_W-1:0]  div;
    } regs_t;

    regs_t r_d, r_q;
    logic [DIV_W-1:0] table_div;

    generate
        if (TABLE_EN) begin : g_table
            logic [DIV_W-1:0] rom [256];
            always_comb begin
                for (int i = 0; i < 256; i++) rom[i] = note_div(CODE_W'(i));
            end
            assign table_div = rom[r_d.code];
        end else begin : g_no_table
            assign table_div = shift_div(r_d.code);
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (io_wr && io_addr == CTRL_ADDR) begin
            r_d.wave = io_wdata[0];
            r_d.tbl  = TABLE_EN ? io_wdata[1] : 1'b0;
        end else if (io_wr && io_addr == DATA_ADDR) begin
            r_d.code = io_wdata;
        end
        r_d.div = r_d.tbl ? table_div : shift_div(r_d.code);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.div  <= DIV_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && io_addr == CTRL_ADDR)      io_rdata = {6'b0, r_q.tbl, r_q.wave};
        else if (io_rd && io_addr == DATA_ADDR) io_rdata = r_q.code;
    end

    assign wave_sel = r_q.wave;
    assign div_val  = r_q.div;

endmodule

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
    parameter int PRESCALE_DIV = 600,
    parameter int CNT_W        = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen
    import tone_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [DIV_W-1:0]   div_val,
    output logic [PHASE_W-1:0] phase,
    output logic               load
);

    typedef struct packed {
        logic [DIV_W-1:0]   cnt;
        logic [PHASE_W-1:0] ph;
        logic               ld;
    } pg_t;

    pg_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ld = 1'b0;
        if (tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = div_val - 1'b1;
                s_d.ph  = s_q.ph + 1'b1;
                s_d.ld  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase = s_q.ph;
    assign load  = s_q.ld;

endmodule

// File: rtl/tone_wave_sel.sv
module tone_wave_sel
    import tone_pkg::*;
(
    input  logic [PHASE_W-1:0] phase,
    input  logic               wave_sel,
    output logic [7:0]         code
);

    always_comb begin
        code = wave_sel ? tri_code(phase) : sine_code(phase);
    end

endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
    import tone_pkg::*;
#(
    parameter int         PRESCALE_DIV = 600,
    parameter int         PRESCALE_W   = 24,
    parameter logic [7:0] CTRL_ADDR    = 8'd98,
    parameter logic [7:0] DATA_ADDR    = 8'd99,
    parameter bit         TABLE_EN     = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic       io_wr,
    input  logic       io_rd,
    output logic [7:0] io_rdata,
    output logic [7:0] dac_code,
    output logic       dac_load
);

    logic               wave_sel;
    logic [DIV_W-1:0]   div_val;
    logic               tick;
    logic [PHASE_W-1:0] phase;

    tone_bus_regs #(
        .CTRL_ADDR(CTRL_ADDR),
        .DATA_ADDR(DATA_ADDR),
        .TABLE_EN (TABLE_EN)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_rdata(io_rdata),
        .wave_sel(wave_sel),
        .div_val (div_val)
    );

    tone_prescaler #(
        .PRESCALE_DIV(PRESCALE_DIV),
        .CNT_W       (PRESCALE_W)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tone_phase_gen u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .div_val(div_val),
        .phase  (phase),
        .load   (dac_load)
    );

    tone_wave_sel u_wave (
        .phase   (phase),
        .wave_sel(wave_sel),
        .code    (dac_code)
    );

endmodule

// File: rtl/tone_gen_checker.sv
module tone_gen_checker
    import tone_pkg::*;
#(
    parameter int PRESCALE_DIV = 600
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               dac_load,
    input logic [PHASE_W-1:0] phase,
    input logic [DIV_W-1:0]   div_val,
    input logic               io_rd,
    input logic [7:0]         io_rdata
);

    // R7: each new sample moves the phase by exactly one, wrapping at 15
    assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> phase == $past(phase) + 4'd1);

    // R7: no load strobe, no phase movement
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load |-> $stable(phase));

    // R5: divisor always within the usable range
    assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_val >= 16'd1 && div_val <= 16'hFFFE);

    // R6: a new sample only follows a prescaler tick
    assert_load_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> $past(tick));

    // R3: read bus idles at zero
    assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'd0);

    generate
        if (PRESCALE_DIV > 1) begin : g_gap
            // R6: ticks are isolated single-cycle pulses
            assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

bind tone_gen_top tone_gen_checker #(.PRESCALE_DIV(PRESCALE_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .dac_load(dac_load),
    .phase   (phase),
    .div_val (div_val),
    .io_rd   (io_rd),
    .io_rdata(io_rdata)
);

// File: tb/tone_gen_top_tb.sv
module tone_gen_top_tb;

    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_rdata;
    logic [7:0] dac_code;
    logic       dac_load;

    int checks = 0;
    int fails  = 0;
    int ep     = 0;

    always #5 clk = ~clk;

    tone_gen_top #(.PRESCALE_DIV(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .dac_code(dac_code), .dac_load(dac_load)
    );

    // Count sample loads seen at the port to track the expected phase
    always @(negedge clk) begin
        if (!rst_n)        ep <= 0;
        else if (dac_load) ep <= ep + 1;
    end

    function automatic int cur_phase();
        return (ep + int'(dac_load)) % 16;
    endfunction

    function automatic int exp_sine(int k);
        real v;
        v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * k / 16.0);
        return $rtoi(v + 0.5);
    endfunction

    function automatic int exp_tri(int k);
        if (k <= 8) return (32 * k > 255) ? 255 : 32 * k;
        return 32 * (16 - k);
    endfunction

    function automatic int exp_note(int c);
        int s, f;
        s = c / 32;
        f = c % 32;
        return (65534 >> s) - f * (65534 >> (s + 5));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output int v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 v = int'(io_rdata);
        io_rd = 1'b0;
    endtask

    task automatic wait_load(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!dac_load);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, n, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(dac_code == 8'd128, "R1 dac_code", dac_code, 128);
        check(dac_load == 1'b0, "R1 dac_load", dac_load, 0);
        bus_read(8'd98, v); check(v == 0, "R1 ctrl read", v, 0);
        bus_read(8'd99, v); check(v == 0, "R1 data read", v, 0);

        // R6 and R4: code 0 gives divisor 1, one sample per tick
        wait_load(n); wait_load(n);
        check(n == P, "R6 tick interval", n, P);

        // R8 and R7: sine sweep across more than two wraps
        for (int i = 0; i < 40; i++) begin
            wait_load(n);
            check(int'(dac_code) == exp_sine(cur_phase()), "R8 sine sample", dac_code, exp_sine(cur_phase()));
        end

        // R2: waveform bit and readback; R11: output switches at once
        bus_write(8'd98, 8'h01);
        check(int'(dac_code) == exp_tri(cur_phase()), "R11 wave switch", dac_code, exp_tri(cur_phase()));
        bus_read(8'd98, v); check(v == 1, "R2 ctrl readback", v, 1);

        // R9 and R7: triangle sweep
        for (int i = 0; i < 40; i++) begin
            wait_load(n);
            check(int'(dac_code) == exp_tri(cur_phase()), "R9 tri sample", dac_code, exp_tri(cur_phase()));
        end

        // R3: data register and ignored foreign addresses
        bus_write(8'd99, 8'h01);
        bus_write(8'd97, 8'hA5);
        bus_write(8'd100, 8'h03);
        bus_read(8'd99, v); check(v == 1, "R3 data readback", v, 1);
        bus_read(8'd98, v); check(v == 1, "R3 ctrl untouched", v, 1);
        bus_read(8'd97, v); check(v == 0, "R3 foreign read", v, 0);

        // R4: shift mapping interval
        wait_load(n); wait_load(n);
        check(n == 256 * P, "R4 code 1 interval", n, 256 * P);

        // R10: switch pitch mid-interval, old interval completes, phase continues
        wait_load(n);
        p0 = cur_phase();
        repeat (40) @(negedge clk);
        bus_write(8'd99, 8'h02);
        wait_load(n);
        check(n + 42 == 256 * P, "R10 old interval kept", n + 42, 256 * P);
        check(cur_phase() == (p0 + 1) % 16 && int'(dac_code) == exp_tri((p0 + 1) % 16),
              "R10 phase continues", dac_code, exp_tri((p0 + 1) % 16));
        wait_load(n);
        check(n == 512 * P, "R10 new interval", n, 512 * P);

        // R2 and R5: note-table mapping sweep over the short-divisor octave
        bus_write(8'd98, 8'h02);
        bus_read(8'd98, v); check(v == 2, "R2 table bit readback", v, 2);
        check(int'(dac_code) == exp_sine(cur_phase()), "R11 back to sine", dac_code, exp_sine(cur_phase()));
        for (int c = 8'hE0; c <= 8'hFF; c++) begin
            bus_write(8'd99, 8'(c));
            wait_load(n); wait_load(n);
            check(n == exp_note(c) * P, "R5 table interval", n, exp_note(c) * P);
        end
        bus_write(8'd99, 8'hC7);
        wait_load(n); wait_load(n);
        check(n == exp_note(8'hC7) * P, "R5 table interval C7", n, exp_note(8'hC7) * P);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule